// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower clock from a reference clock and switches it on and off under register control. A byte-wide register port, synchronous to the reference clock, exposes two registers. One holds a ratio code. The other holds the run-enable bit and a read-only busy flag. The divided output runs at a 50% duty cycle. The ratio code selects a period of 2, 4, 8, 16, 32, 64 or 128 reference cycles.

The run-enable bit passes through a two-flop synchronizer before it reaches the gate. The gate opens and closes only while the divided output is low, so every high and low phase is either full length or absent. Software changes the ratio while running in four steps: it clears the enable bit, waits for busy to fall, writes the new code and then sets the enable bit again. A ratio written while the output is enabled is held back and takes effect once the output has stopped.

Top module: `refclk_gated_divider`

## Requirements
- R1: Reset, whether applied at start-up or while running, forces the output low at once. It clears the enable bit, selects ratio code 0 and clears busy. After reset, both registers read 0x00.
- R2: A write to address 0x43 targets the ratio register, which reads its active code in bits 2:0. A write to address 0x46 targets the enable register, and only bit 7 of that write is stored. Bit 7 reads back the stored enable. Any other address reads 0x00, and a write to it leaves the output and both registers unchanged.
- R3: With ratio code c active and the output running, every high phase lasts exactly 2^c reference cycles.
- R4: Writing a code value of 7 or above (the whole byte is compared) leaves the active ratio unchanged.
- R5: When bit 7 is set at write edge W, the output's first rising edge follows at reference edge W+3+2^c. This is within 2 reference periods plus 3 output periods.
- R6: When bit 7 is cleared at write edge W, no rising edge occurs after edge W+2. The output is low from edge W+3+2^c onward.
- R7: The output is low whenever the gate is closed, and it is low when the gate opens. While running, every low phase between two high phases lasts exactly 2^c reference cycles.
- R8: A valid code written while the enable bit is set, or while the output is still running, does not change the active ratio or its read-back. That code becomes active once enable is clear and the output has stopped.
- R9: Bit 0 of the enable register reads 1 after an enable change until the gate has followed it. When bit 7 is set at edge W, bit 0 reads 1 after edges W, W+1 and W+2 and reads 0 after edge W+3. Bit 0 also reads 1 while a ratio code is held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Write strobe, one write per asserted cycle |
| reg_rdata_o | output | 8 | Read data for the addressed register, combinational |
| clk_div_o | output | 1 | Gated divided clock |

## Verification
The assertions assume the following about the inputs:
- Register accesses arrive synchronous to the reference clock, with the address and data stable around the edge on which the strobe is sampled.
- Reset may arrive at any time.
- The enable bit may change at any point in a divided period, including in the middle of a high phase.

The stimulus drives every input on the falling reference edge and samples all outputs shortly after it. Ratio changes follow both the stop-then-write order and the out-of-order write that must be held back. Enable is cleared at arbitrary phases of the running output, so both the immediate stop during a low phase and the deferred stop after a high phase occur.

// File: rtl/refclk_gated_divider.sv
module refclk_gated_divider #(
  parameter int          CODE_W    = 3,
  parameter int          NUM_CODES = 7,
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  DIV_ADDR  = 8'h43,
  parameter logic [7:0]  EN_ADDR   = 8'h46
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              clk_div_o
);
  localparam int CNT_W  = NUM_CODES - 1;
  localparam int EN_BIT = DATA_W - 1;

  logic              en_q, en_s1, en_s2, run_q, ph_q, pend_v;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] div_q, pend_q;
  logic [CNT_W:0]    half_w;
  logic              wr_div, wr_en, code_ok, idle, wrap, busy;

  assign wr_div  = reg_we_i && (reg_addr_i == ADDR_W'(DIV_ADDR));
  assign wr_en   = reg_we_i && (reg_addr_i == ADDR_W'(EN_ADDR));
  assign code_ok = reg_wdata_i < DATA_W'(NUM_CODES);
  assign idle    = !en_q && !run_q;
  assign half_w  = (CNT_W+1)'(1) << div_q;
  assign wrap    = ({1'b0, cnt_q} == half_w - (CNT_W+1)'(1));
  assign busy    = (en_q != run_q) || pend_v;
  assign clk_div_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else begin
      if (wr_en) en_q <= reg_wdata_i[EN_BIT];
      if (wr_div && code_ok) begin
        if (idle) begin
          div_q  <= reg_wdata_i[CODE_W-1:0];
          pend_v <= 1'b0;
        end else begin
          pend_q <= reg_wdata_i[CODE_W-1:0];
          pend_v <= 1'b1;
        end
      end else if (pend_v && idle) begin
        div_q  <= pend_q;
        pend_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
    end else begin
      en_s1 <= en_q;
      en_s2 <= en_s1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      if (en_s2) run_q <= 1'b1;
    end else if (!en_s2 && !ph_q) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
      if (!en_s2) run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(DIV_ADDR)) begin
      reg_rdata_o[CODE_W-1:0] = div_q;
    end else if (reg_addr_i == ADDR_W'(EN_ADDR)) begin
      reg_rdata_o[EN_BIT] = en_q;
      reg_rdata_o[0]      = busy;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clk_div_o); // R7
  AST_OPEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> !clk_div_o); // R7
  AST_CLOSE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !clk_div_o); // R6
  AST_START_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(en_q, 3)); // R5
  AST_RATIO_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(div_q)); // R8
  AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_div && !code_ok && !pend_v) |=> $stable(div_q)); // R4
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q < CODE_W'(NUM_CODES)); // R4
endmodule

// File: tb/refclk_gated_divider_bench.sv
`timescale 1ns/1ps
module refclk_gated_divider_bench;
  localparam logic [7:0] A_DIV = 8'h43;
  localparam logic [7:0] A_EN  = 8'h46;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic dclk;

  refclk_gated_divider u_refclk_gated_divider (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .clk_div_o(dclk));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int  exp_rise_q[$];
  int  cur_half = 1;
  bit  first_pending = 1'b0;
  int  stop_from = 1 << 30;
  int  last_rise = -1, last_fall = -1;
  logic prev_d = 1'b0;

  always @(negedge clk) begin
    int e;
    if (rst_n) begin
      if (dclk && !prev_d) begin
        check(cyc <= stop_from, "R6 rise after stop", cyc, stop_from);
        if (first_pending) begin
          first_pending = 1'b0;
          if (exp_rise_q.size() > 0) begin
            e = exp_rise_q.pop_front();
            check(cyc == e, "R5 first rising edge", cyc, e);
          end
        end else if (last_fall >= 0) begin
          check(cyc - last_fall == cur_half, "R7 low phase", cyc - last_fall, cur_half);
        end
        last_rise = cyc;
      end
      if (!dclk && prev_d)
        check(cyc - last_rise == cur_half, "R3 high phase", cyc - last_rise, cur_half);
      if (!dclk && prev_d) last_fall = cyc;
    end
    prev_d = dclk;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int wc);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    wc = cyc; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #2 v = rdata;
  endtask

  task automatic start(input int code);
    int wc;
    cur_half = 1 << code;
    first_pending = 1'b1;
    stop_from = 1 << 30;
    wr(A_EN, 8'h80, wc);
    exp_rise_q.push_back(wc + 3 + cur_half);
    #2 check(rdata[0] == 1'b1, "R9 busy after enable", rdata[0], 1);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      #2 check(rdata[0] == (k < 3), "R9 busy window", rdata[0], int'(k < 3));
    end
  endtask

  task automatic stop();
    int wc;
    wr(A_EN, 8'h00, wc);
    stop_from = wc + 2;
    repeat (3 + cur_half) @(negedge clk);
    #2 check(dclk == 1'b0, "R6 low after stop", dclk, 0);
    repeat (6 * cur_half + 2) @(negedge clk);
    #2 check(dclk == 1'b0, "R6 stays low", dclk, 0);
  endtask

  initial begin
    logic [7:0] v;
    int wc;
    repeat (3) @(negedge clk);
    #2 check(dclk == 1'b0, "R1 output low in reset", dclk, 0);
    rst_n = 1'b1;
    rd(A_DIV, v); check(v == 8'h00, "R1 ratio reg after reset", v, 0);
    rd(A_EN, v);  check(v == 8'h00, "R1 enable reg after reset", v, 0);

    wr(8'h44, 8'h80, wc);
    repeat (10) @(negedge clk);
    #2 check(dclk == 1'b0, "R2 stray write leaves output off", dclk, 0);
    rd(A_EN, v);  check(v == 8'h00, "R2 stray write leaves enable", v, 0);
    rd(8'h44, v); check(v == 8'h00, "R2 unmapped read", v, 0);
    wr(A_DIV, 8'h03, wc);
    rd(A_DIV, v); check(v == 8'h03, "R2 ratio readback", v, 3);

    wr(A_DIV, 8'h07, wc);
    rd(A_DIV, v); check(v == 8'h03, "R4 code 7 ignored", v, 3);
    wr(A_DIV, 8'hFF, wc);
    rd(A_DIV, v); check(v == 8'h03, "R4 code 0xFF ignored", v, 3);
    wr(A_DIV, 8'h0B, wc);
    rd(A_DIV, v); check(v == 8'h03, "R4 code 0x0B ignored", v, 3);

    for (int c = 0; c < 7; c++) begin
      wr(A_DIV, 8'(c), wc);
      rd(A_DIV, v); check(v == 8'(c), "R3 code accepted", v, c);
      start(c);
      rd(A_EN, v); check(v[7] == 1'b1, "R2 enable readback", v[7], 1);
      repeat (cur_half * 9 + c) @(negedge clk);
      stop();
    end

    wr(A_DIV, 8'h02, wc);
    start(2);
    repeat (13) @(negedge clk);
    wr(A_DIV, 8'h05, wc);
    rd(A_DIV, v); check(v == 8'h02, "R8 held code not active", v, 2);
    rd(A_EN, v);  check(v[0] == 1'b1, "R9 busy while held", v[0], 1);
    repeat (30) @(negedge clk);
    stop();
    rd(A_DIV, v); check(v == 8'h05, "R8 held code applied", v, 5);
    rd(A_EN, v);  check(v == 8'h00, "R9 busy cleared", v, 0);
    start(5);
    repeat (200) @(negedge clk);
    stop();

    wr(A_DIV, 8'h01, wc);
    start(1);
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    #2 check(dclk == 1'b0, "R1 reset while running", dclk, 0);
    rd(A_DIV, v); check(v == 8'h00, "R1 ratio cleared", v, 0);
    rd(A_EN, v);  check(v == 8'h00, "R1 enable cleared", v, 0);
    @(negedge clk);
    rst_n = 1'b1;
    first_pending = 1'b0;
    repeat (10) @(negedge clk);
    #2 check(dclk == 1'b0, "R1 stays off after reset", dclk, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule